// File: doc/BRIEF.md
# Asymmetric Center-Aligned PWM Channel Pair

This block turns the count of an external up/down (center-aligned) counter into one PWM waveform whose two edges come from two separate compare values. While the counter climbs, the reference follows the comparison against the first compare value. While it falls, the reference follows the comparison against the second. The pulse therefore need not be symmetric about the middle of the period, and its position within the period can be moved freely. The counter itself, and the update event that marks a period boundary, are produced outside the block.

Both compare values and the counter top are held in shadow registers. These load only when the update strobe is high, so a new setting never takes effect partway through a period. A 4-bit mode code selects one of two variants, and a polarity input sets the level seen at the pin. Whenever the counter is not running center-aligned, or the code is not one of the two asymmetric codes, the reference is held low.

Top module: `asym_pwm`

## Requirements
- R1: While rst_ni is low, ref_o and pin_o are both 0. All three shadow registers reset to 0.
- R2: In variant 1 (mode_i = 4'b1110), with center_en_i high and cnt_down_i low, the reference is 1 exactly when cnt_i is below the shadowed first compare value.
- R3: In variant 1, with center_en_i high and cnt_down_i high, the reference is 1 exactly when cnt_i is at or below the shadowed second compare value.
- R4: Variant 2 (mode_i = 4'b1111) gives the logical complement of variant 1 for the same count, direction and shadow values.
- R5: When center_en_i is low, the next reference is 0, whatever the other inputs are.
- R6: When mode_i holds any code other than 4'b1110 or 4'b1111, the next reference is 0.
- R7: cmp_a_i, cmp_b_i and top_i reach the shadow registers only on a clock edge where load_i is high. That edge itself still uses the old shadow values. Changing these inputs while load_i is low has no effect on ref_o.
- R8: pin_o equals ref_o XOR the value pol_i had at the same clock edge.
- R9: ref_o and pin_o are registered. They show the result for the inputs sampled at the previous rising edge.
- R10: If a shadowed compare value exceeds the shadowed top, the comparison for that direction counts as active for the whole half-period. Variant 1 then drives the reference high, and variant 2 drives it low.
- R11: With both compare values at 0, variant 1 is never active while counting up, and is active only at count 0 while counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current value of the external counter |
| cnt_down_i | input | 1 | 1 while the counter is counting down |
| center_en_i | input | 1 | 1 when the counter runs center-aligned |
| mode_i | input | 4 | Output mode code (1110 variant 1, 1111 variant 2) |
| cmp_a_i | input | CNT_W | First compare value (up-count edge), preload |
| cmp_b_i | input | CNT_W | Second compare value (down-count edge), preload |
| top_i | input | CNT_W | Counter top (period), preload |
| load_i | input | 1 | Update event: copies the preloads into the shadows |
| pol_i | input | 1 | 1 inverts the reference at the pin |
| ref_o | output | 1 | Output reference |
| pin_o | output | 1 | Reference after polarity |

## Verification
The assertions assume that, while center-aligned mode is on, the counter never goes past the shadowed top. Their up and down checks rely on this. The stimulus keeps to it in two ways. It asserts the update strobe only in cycles where center_en_i is low, and each sweep runs the count from 0 up to the current top and back down to 1. Compare values above the top and equal to zero are placed inside these legal sweeps. They exercise the saturation and edge cases without breaking the range rule.

// File: rtl/asym_pwm_pkg.sv
package asym_pwm_pkg;

  localparam logic [3:0] MODE_ASYM1 = 4'b1110;
  localparam logic [3:0] MODE_ASYM2 = 4'b1111;

  typedef enum logic [1:0] {
    VAR_OFF = 2'd0,
    VAR_1   = 2'd1,
    VAR_2   = 2'd2
  } pair_var_e;

  function automatic pair_var_e decode_mode(input logic [3:0] code);
    case (code)
      MODE_ASYM1: return VAR_1;
      MODE_ASYM2: return VAR_2;
      default:    return VAR_OFF;
    endcase
  endfunction

endpackage

// File: rtl/asym_pwm_shadow.sv
module asym_pwm_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [CNT_W-1:0] cmp_b_o,
  output logic [CNT_W-1:0] top_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_a_o <= '0;
      cmp_b_o <= '0;
      top_o   <= '0;
    end else if (load_i) begin
      cmp_a_o <= cmp_a_i;
      cmp_b_o <= cmp_b_i;
      top_o   <= top_i;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(cmp_a_o) && $stable(cmp_b_o) && $stable(top_o)));

endmodule

// File: rtl/asym_pwm_cmp.sv
module asym_pwm_cmp #(
  parameter int CNT_W     = 16,
  parameter bit INCLUSIVE = 1'b0
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] top_i,
  output logic             act_o
);

  logic sat;
  logic hit;

  // compare beyond top: active for the whole half-period
  assign sat = (cmp_i > top_i);

  if (INCLUSIVE) begin : g_incl
    assign hit = (cnt_i <= cmp_i);
  end else begin : g_excl
    assign hit = (cnt_i < cmp_i);
  end

  assign act_o = sat | hit;

endmodule

// File: rtl/asym_pwm.sv
module asym_pwm
  import asym_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             center_en_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             load_i,
  input  logic             pol_i,
  output logic             ref_o,
  output logic             pin_o
);

  localparam int NUM_CMP = 2;

  logic [CNT_W-1:0] a_q, b_q, t_q;
  logic [CNT_W-1:0] cmp_sel [NUM_CMP];
  logic [NUM_CMP-1:0] act;
  pair_var_e var_sel;
  logic base_d, ref_d;

  asym_pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .cmp_a_i (cmp_a_i),
    .cmp_b_i (cmp_b_i),
    .top_i   (top_i),
    .cmp_a_o (a_q),
    .cmp_b_o (b_q),
    .top_o   (t_q)
  );

  assign cmp_sel[0] = a_q;
  assign cmp_sel[1] = b_q;

  // index 0: up-count rule (strict), index 1: down-count rule (inclusive)
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    asym_pwm_cmp #(.CNT_W(CNT_W), .INCLUSIVE(g == 1)) u_cmp (
      .cnt_i (cnt_i),
      .cmp_i (cmp_sel[g]),
      .top_i (t_q),
      .act_o (act[g])
    );
  end

  assign var_sel = decode_mode(mode_i);
  assign base_d  = cnt_down_i ? act[1] : act[0];

  always_comb begin
    ref_d = 1'b0;
    if (center_en_i) begin
      case (var_sel)
        VAR_1:   ref_d = base_d;
        VAR_2:   ref_d = ~base_d;
        default: ref_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_o <= 1'b0;
      pin_o <= 1'b0;
    end else begin
      ref_o <= ref_d;
      pin_o <= ref_d ^ pol_i;
    end
  end

  // R5
  center_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !center_en_i |=> !ref_o);

  // R6
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_ASYM1 && mode_i != MODE_ASYM2) |=> !ref_o);

  // R8
  pin_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (pin_o == (ref_o ^ $past(pol_i))));

  // R2
  up_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (center_en_i && mode_i == MODE_ASYM1 && !cnt_down_i && cnt_i == '0 && a_q != '0)
    |=> ref_o);

  // R3
  dn_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (center_en_i && mode_i == MODE_ASYM1 && cnt_down_i && cnt_i > b_q && cnt_i <= t_q)
    |=> !ref_o);

  // R4
  var2_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (center_en_i && mode_i == MODE_ASYM2 && !cnt_down_i && cnt_i == '0 && a_q != '0)
    |=> !ref_o);

  // R10 precondition: counter stays within the shadowed top
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    center_en_i |-> (cnt_i <= t_q));

endmodule

// File: tb/sim_asym_pwm.sv
module sim_asym_pwm;

  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] cnt_i = '0;
  logic         cnt_down_i = 1'b0;
  logic         center_en_i = 1'b0;
  logic [3:0]   mode_i = 4'b0000;
  logic [W-1:0] cmp_a_i = '0;
  logic [W-1:0] cmp_b_i = '0;
  logic [W-1:0] top_i = '0;
  logic         load_i = 1'b0;
  logic         pol_i = 1'b0;
  logic         ref_o, pin_o;

  always #4 clk_i = ~clk_i;

  asym_pwm #(.CNT_W(W)) u0 (.*);

  typedef struct {
    logic  r;
    logic  p;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench copy of the shadow state
  logic [W-1:0] m_a = '0, m_b = '0, m_top = '0;

  function automatic logic model_ref(logic [W-1:0] c, logic d, logic ce, logic [3:0] m);
    logic r1;
    if (!ce || (m != 4'b1110 && m != 4'b1111)) return 1'b0;
    if (d) r1 = (c <= m_b) || (m_b > m_top);
    else   r1 = (c < m_a)  || (m_a > m_top);
    return (m == 4'b1111) ? ~r1 : r1;
  endfunction

  // driver: apply inputs at negedge, queue the result due after the next rise (R9)
  task automatic step(input logic [W-1:0] c, input logic d, input logic ce,
                      input logic [3:0] m, input logic p, input logic ld, input string tag);
    exp_t e;
    @(negedge clk_i);
    cnt_i = c; cnt_down_i = d; center_en_i = ce; mode_i = m; pol_i = p; load_i = ld;
    e.r = model_ref(c, d, ce, m);
    e.p = e.r ^ p;
    e.tag = tag;
    q.push_back(e);
    if (ld) begin
      m_a = cmp_a_i; m_b = cmp_b_i; m_top = top_i;
    end
  endtask

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] t,
                      input string tag);
    @(negedge clk_i);
    cmp_a_i = a; cmp_b_i = b; top_i = t;
    step('0, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b1, tag);
  endtask

  task automatic sweep(input logic [3:0] m, input logic p, input logic ce, input string tag);
    for (int i = 0; i < int'(m_top); i++) step(W'(i), 1'b0, ce, m, p, 1'b0, tag);
    for (int i = int'(m_top); i >= 1; i--) step(W'(i), 1'b1, ce, m, p, 1'b0, tag);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (ref_o !== e.r || pin_o !== e.p) begin
          n_fail++;
          $display("FAIL %s ref/pin=%b%b expected %b%b", e.tag, ref_o, pin_o, e.r, e.p);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pol_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    n_chk++;
    if (ref_o !== 1'b0 || pin_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset ref/pin=%b%b expected 00", ref_o, pin_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 first load, R5 idle outputs
    load(16'd3, 16'd7, 16'd10, "R7 load");
    step(16'd2, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b0, "R5 center off");

    // R2 up rule, R3 down rule
    sweep(4'b1110, 1'b0, 1'b1, "R2 R3 variant1");

    // R7 preloads changed without an update: no effect
    @(negedge clk_i);
    cmp_a_i = 16'd9; cmp_b_i = 16'd1; top_i = 16'd12;
    sweep(4'b1110, 1'b0, 1'b1, "R7 no load");
    step('0, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b1, "R7 update");
    sweep(4'b1110, 1'b0, 1'b1, "R7 new shadow");

    // R4 variant 2, R8 inverted pin
    sweep(4'b1111, 1'b1, 1'b1, "R4 R8 variant2");
    sweep(4'b1110, 1'b1, 1'b1, "R8 variant1 pol");

    // R6 unsupported codes
    sweep(4'b0110, 1'b0, 1'b1, "R6 code 0110");
    sweep(4'b1101, 1'b1, 1'b1, "R6 code 1101");

    // R5 center disabled during a sweep
    sweep(4'b1110, 1'b0, 1'b0, "R5 sweep off");

    // R11 zero compares
    load(16'd0, 16'd0, 16'd6, "R11 load");
    sweep(4'b1110, 1'b0, 1'b1, "R11 zero cmp");

    // R10 compares above top
    load(16'd9, 16'd20, 16'd6, "R10 load");
    sweep(4'b1110, 1'b0, 1'b1, "R10 sat v1");
    sweep(4'b1111, 1'b0, 1'b1, "R10 sat v2");

    // asymmetric placement: early rise, late fall
    load(16'd1, 16'd5, 16'd8, "R2 load asym");
    sweep(4'b1110, 1'b0, 1'b1, "R2 R3 asym");

    step('0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "R5 tail");
    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule